// File: doc/BRIEF.md
# Byte-Swapping IDE Register Window Decoder

This block is a memory-mapped slave that presents a disk-controller task file through a 4 KB address window. Registers sit on a 16-byte stride, so the register index is address bits 11:4. Byte accesses reach the seven task-file registers, the device-control register (on writes) and the status register (on reads), and both registers are reachable at two aliased indices. Halfword and word accesses reach only the data port at index 0, and their byte order is reversed in both directions. Reads from unmapped places return all ones, and writes to them are dropped.

Requests arrive on a valid/ready channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. A read is answered on a response channel one cycle after it is accepted. The response stays valid, with stable data, until `rsp_ready` is seen high. While a response is held back, `req_ready` is low, so the requester is stalled. The register file downstream is reached through a plain single-cycle port. In the cycle a request is accepted, the decoder drives a target code, an index, write data and one strobe. It samples `dn_rdata` at the same clock edge.

Top module: `ide_window_decoder`

## Requirements
- R1: The register index is address bits 11:4. Addresses that differ only above bit 11 or in bits 3:0 select the same register.
- R2: A byte access (size 0) at index 1 to 7 selects the task file (target code 1), with `dn_idx` equal to the index. A write passes `req_wdata[7:0]` on `dn_wdata[7:0]`. A read returns `dn_rdata[7:0]` in response bits 7:0, and the upper bits are zero.
- R3: A byte write at index 8 or 22 selects the device-control register (code 2). A byte read at index 8 or 22 selects the status register (code 3) and returns its value in bits 7:0.
- R4: A byte read at any other index returns 0x000000FF. A byte write there raises no downstream strobe.
- R5: A halfword access (size 1) at index 0 selects the data port in 16-bit mode (code 4). The two bytes are swapped on both writes and reads, and the upper 16 bits are zero.
- R6: A word access (size 2) at index 0 selects the data port in 32-bit mode (code 5). All four bytes are reversed on both writes and reads.
- R7: A halfword or word access at a non-zero index is unmapped, and so is any access of size 3. Reads return 0x0000FFFF for a halfword and 0xFFFFFFFF otherwise. Writes raise no strobe.
- R8: A read response becomes valid in the cycle after acceptance. It holds its data until the cycle in which `rsp_ready` is high.
- R9: `req_ready` is low while a response is valid and `rsp_ready` is low. Writes produce no response.
- R10: Each accepted mapped access raises exactly one single-cycle strobe, either `dn_we` or `dn_re`. The target code is 0 whenever no request is accepted. A status read leaves no state behind in the decoder.
- R11: After reset, no response is valid and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data, right-aligned |
| dn_sel | output | 3 | Target code (0 none, 1 task file, 2 control, 3 status, 4 data16, 5 data32) |
| dn_idx | output | 3 | Task-file register number |
| dn_we | output | 1 | Downstream write strobe |
| dn_re | output | 1 | Downstream read strobe |
| dn_wdata | output | 32 | Downstream write data, already swapped |
| dn_rdata | input | 32 | Downstream read data, unswapped |

## Verification
Two things can happen in the same clock edge: a held response is drained, and a new request is accepted. The bench sets up this collision by leaving `rsp_ready` low after a task-file read while it offers a second read. It checks that the second read is stalled and that the first response stays stable. It then raises `rsp_ready` in the same cycle the second read is still pending, and checks that the next response carries the second read's data with no gap and no lost strobe.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    TGT_NONE     = 3'd0,
    TGT_TASKFILE = 3'd1,
    TGT_CONTROL  = 3'd2,
    TGT_STATUS   = 3'd3,
    TGT_DATA16   = 3'd4,
    TGT_DATA32   = 3'd5
  } target_e;
endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_win_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WIN_BYTES = 4096,
  parameter int STRIDE    = 16,
  parameter int TF_FIRST  = 1,
  parameter int TF_LAST   = 7,
  parameter int CTL_IDX_A = 8,
  parameter int CTL_IDX_B = 22
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              is_write,
  output target_e           target,
  output logic [2:0]        tf_idx
);
  localparam int WIN_BITS    = $clog2(WIN_BYTES);
  localparam int STRIDE_BITS = $clog2(STRIDE);
  localparam int IDX_W       = WIN_BITS - STRIDE_BITS;
  localparam logic [IDX_W-1:0] TF_LO = IDX_W'(TF_FIRST);
  localparam logic [IDX_W-1:0] TF_HI = IDX_W'(TF_LAST);
  localparam logic [IDX_W-1:0] CTL_A = IDX_W'(CTL_IDX_A);
  localparam logic [IDX_W-1:0] CTL_B = IDX_W'(CTL_IDX_B);

  logic [IDX_W-1:0] idx;
  assign idx = addr[WIN_BITS-1:STRIDE_BITS];

  always_comb begin
    target = TGT_NONE;
    tf_idx = 3'd0;
    unique case (acc_size_e'(size))
      SZ_BYTE: begin
        if (idx >= TF_LO && idx <= TF_HI) begin
          target = TGT_TASKFILE;
          tf_idx = idx[2:0];
        end else if (idx == CTL_A || idx == CTL_B) begin
          target = is_write ? TGT_CONTROL : TGT_STATUS;
        end
      end
      SZ_HALF: if (idx == '0) target = TGT_DATA16;
      SZ_WORD: if (idx == '0) target = TGT_DATA32;
      default: target = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/ide_win_swap.sv
module ide_win_swap #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] din,
  output logic [LANES*8-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*8 +: 8] = din[(LANES-1-g)*8 +: 8];
  end
endmodule

// File: rtl/ide_win_resp.sv
module ide_win_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          can_accept
);
  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ide_window_decoder.sv
module ide_window_decoder
  import ide_win_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WIN_BYTES = 4096,
  parameter int STRIDE    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [2:0]        dn_sel,
  output logic [2:0]        dn_idx,
  output logic              dn_we,
  output logic              dn_re,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata
);
  localparam int DW = 32;

  target_e    tgt;
  logic [2:0] tf_idx;
  logic       accept;
  logic       mapped;
  logic [15:0] w16_sw, r16_sw;
  logic [31:0] w32_sw, r32_sw;
  logic [31:0] rd_fmt;

  ide_win_decode #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .STRIDE(STRIDE)
  ) dec_i (
    .addr(req_addr), .size(req_size), .is_write(req_write),
    .target(tgt), .tf_idx(tf_idx)
  );

  ide_win_swap #(.LANES(2)) wsw16_i (.din(req_wdata[15:0]), .dout(w16_sw));
  ide_win_swap #(.LANES(4)) wsw32_i (.din(req_wdata),       .dout(w32_sw));
  ide_win_swap #(.LANES(2)) rsw16_i (.din(dn_rdata[15:0]),  .dout(r16_sw));
  ide_win_swap #(.LANES(4)) rsw32_i (.din(dn_rdata),        .dout(r32_sw));

  assign accept = req_valid && req_ready;
  assign mapped = (tgt != TGT_NONE);

  assign dn_sel = accept ? 3'(tgt) : 3'(TGT_NONE);
  assign dn_idx = accept ? tf_idx : 3'd0;
  assign dn_we  = accept && mapped && req_write;
  assign dn_re  = accept && mapped && !req_write;

  always_comb begin
    unique case (tgt)
      TGT_TASKFILE, TGT_CONTROL: dn_wdata = {24'd0, req_wdata[7:0]};
      TGT_DATA16:                dn_wdata = {16'd0, w16_sw};
      TGT_DATA32:                dn_wdata = w32_sw;
      default:                   dn_wdata = 32'd0;
    endcase
  end

  always_comb begin
    unique case (tgt)
      TGT_TASKFILE, TGT_STATUS: rd_fmt = {24'd0, dn_rdata[7:0]};
      TGT_DATA16:               rd_fmt = {16'd0, r16_sw};
      TGT_DATA32:               rd_fmt = r32_sw;
      default: begin
        if (acc_size_e'(req_size) == SZ_BYTE)      rd_fmt = 32'h0000_00FF;
        else if (acc_size_e'(req_size) == SZ_HALF) rd_fmt = 32'h0000_FFFF;
        else                                       rd_fmt = 32'hFFFF_FFFF;
      end
    endcase
  end

  ide_win_resp #(.DW(DW)) resp_i (
    .clk(clk), .rst_n(rst_n),
    .load(accept && !req_write), .load_data(rd_fmt),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .can_accept(req_ready)
  );
endmodule

// File: rtl/ide_window_decoder_chk.sv
module ide_window_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic [2:0]  dn_sel,
  input logic        dn_we,
  input logic        dn_re
);
  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_we && dn_re));

  p_idle_no_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |-> (dn_sel == 3'd0 && !dn_we && !dn_re));

  p_rsp_next_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_write_no_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);
endmodule

bind ide_window_decoder ide_window_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .dn_sel(dn_sel), .dn_we(dn_we), .dn_re(dn_re)
);

// File: tb/ide_window_decoder_tb_top.sv
`timescale 1ns/1ps
module ide_window_decoder_tb_top;
  localparam logic [31:0] DATA_VAL = 32'hA1B2C3D4;
  localparam logic [7:0]  STAT_VAL = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, dn_we, dn_re;
  logic [31:0] rsp_rdata, dn_wdata, dn_rdata;
  logic [2:0]  dn_sel, dn_idx;

  int n_checks = 0, n_fail = 0, cycles = 0;
  logic [2:0]  s_sel, s_idx;
  logic        s_we, s_re;
  logic [31:0] s_wdata;

  always #5 clk = ~clk;

  ide_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .dn_sel(dn_sel), .dn_idx(dn_idx), .dn_we(dn_we),
    .dn_re(dn_re), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  // downstream register file model
  always_comb begin
    case (dn_sel)
      3'd1:       dn_rdata = {24'd0, 8'h10 + {5'd0, dn_idx}};
      3'd3:       dn_rdata = {24'd0, STAT_VAL};
      3'd4, 3'd5: dn_rdata = DATA_VAL;
      default:    dn_rdata = 32'hDEAD_BEEF;
    endcase
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access; downstream signals sampled in the accept cycle, response next cycle
  task automatic access(input logic wr, input logic [1:0] sz,
                        input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output logic rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = addr; req_wdata = wd;
    #1;
    s_sel = dn_sel; s_idx = dn_idx; s_we = dn_we; s_re = dn_re; s_wdata = dn_wdata;
    @(negedge clk);
    rd = rsp_rdata; rv = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R11 req_ready after reset", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_taskfile();
    logic [31:0] rd; logic rv;
    access(1'b0, 2'd0, 32'h0000_0030, 32'd0, rd, rv);
    chk("R2 read sel", {29'd0, s_sel}, 32'd1);
    chk("R2 read idx", {29'd0, s_idx}, 32'd3);
    chk("R8 read rsp_valid next cycle", {31'd0, rv}, 32'd1);
    chk("R2 read data", rd, 32'h0000_0013);
    access(1'b0, 2'd0, 32'hABCD_F07B, 32'd0, rd, rv);
    chk("R1 alias idx", {29'd0, s_idx}, 32'd7);
    chk("R1 alias data", rd, 32'h0000_0017);
    access(1'b1, 2'd0, 32'h0000_0050, 32'h1234_56C9, rd, rv);
    chk("R2 write strobe", {30'd0, s_we, s_re}, 32'd2);
    chk("R2 write data", s_wdata, 32'h0000_00C9);
    chk("R9 write gives no response", {31'd0, rv}, 32'd0);
  endtask

  task automatic t_control_status();
    logic [31:0] rd; logic rv;
    access(1'b1, 2'd0, 32'h0000_0080, 32'h0000_0006, rd, rv);
    chk("R3 ctl write sel idx8", {29'd0, s_sel}, 32'd2);
    chk("R3 ctl write data", s_wdata, 32'h0000_0006);
    access(1'b1, 2'd0, 32'h0000_0160, 32'h0000_0002, rd, rv);
    chk("R3 ctl write sel idx22", {29'd0, s_sel}, 32'd2);
    access(1'b0, 2'd0, 32'h0000_0168, 32'd0, rd, rv);
    chk("R3 status read sel idx22", {29'd0, s_sel}, 32'd3);
    chk("R3 status read data", rd, {24'd0, STAT_VAL});
    access(1'b0, 2'd0, 32'h0000_0080, 32'd0, rd, rv);
    chk("R10 repeated status read", rd, {24'd0, STAT_VAL});
    access(1'b0, 2'd0, 32'h0000_0010, 32'd0, rd, rv);
    chk("R10 access after status read", rd, 32'h0000_0011);
  endtask

  task automatic t_unmapped_byte();
    logic [31:0] rd; logic rv;
    access(1'b0, 2'd0, 32'h0000_0000, 32'd0, rd, rv);
    chk("R4 byte read idx0", rd, 32'h0000_00FF);
    chk("R4 byte read idx0 no strobe", {30'd0, s_we, s_re}, 32'd0);
    access(1'b1, 2'd0, 32'h0000_0090, 32'h0000_0055, rd, rv);
    chk("R4 byte write idx9 no strobe", {30'd0, s_we, s_re}, 32'd0);
    access(1'b0, 2'd0, 32'h0000_0FF0, 32'd0, rd, rv);
    chk("R4 byte read idx255", rd, 32'h0000_00FF);
  endtask

  task automatic t_data_port();
    logic [31:0] rd; logic rv;
    access(1'b1, 2'd1, 32'h0000_0000, 32'h0000_1234, rd, rv);
    chk("R5 half write sel", {29'd0, s_sel}, 32'd4);
    chk("R5 half write swap", s_wdata, 32'h0000_3412);
    access(1'b0, 2'd1, 32'h0000_1004, 32'd0, rd, rv);
    chk("R5 half read swap", rd, 32'h0000_D4C3);
    access(1'b1, 2'd2, 32'h0000_0000, 32'h1122_3344, rd, rv);
    chk("R6 word write sel", {29'd0, s_sel}, 32'd5);
    chk("R6 word write reverse", s_wdata, 32'h4433_2211);
    access(1'b0, 2'd2, 32'h0000_0000, 32'd0, rd, rv);
    chk("R6 word read reverse", rd, 32'hD4C3_B2A1);
  endtask

  task automatic t_wide_unmapped();
    logic [31:0] rd; logic rv;
    access(1'b0, 2'd1, 32'h0000_0010, 32'd0, rd, rv);
    chk("R7 half read idx1", rd, 32'h0000_FFFF);
    access(1'b0, 2'd2, 32'h0000_0080, 32'd0, rd, rv);
    chk("R7 word read idx8", rd, 32'hFFFF_FFFF);
    access(1'b0, 2'd3, 32'h0000_0000, 32'd0, rd, rv);
    chk("R7 size3 read", rd, 32'hFFFF_FFFF);
    access(1'b1, 2'd2, 32'h0000_0020, 32'hFFFF_0000, rd, rv);
    chk("R7 word write idx2 no strobe", {30'd0, s_we, s_re}, 32'd0);
    access(1'b1, 2'd3, 32'h0000_0000, 32'h0000_1111, rd, rv);
    chk("R7 size3 write no strobe", {30'd0, s_we, s_re}, 32'd0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd0; req_addr = 32'h20;
    #1 chk("R9 ready before stall", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_addr = 32'h50;
    #1;
    chk("R9 stalled ready low", {31'd0, req_ready}, 32'd0);
    chk("R10 no strobe while stalled", {30'd0, dn_we, dn_re}, 32'd0);
    chk("R8 first rsp", rsp_rdata, 32'h0000_0012);
    @(negedge clk);
    chk("R8 rsp held valid", {31'd0, rsp_valid}, 32'd1);
    chk("R8 rsp held data", rsp_rdata, 32'h0000_0012);
    rsp_ready = 1'b1;
    #1;
    chk("R9 drain and accept same cycle", {31'd0, req_ready}, 32'd1);
    chk("R10 second read strobe", {30'd0, dn_we, dn_re}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second rsp valid", {31'd0, rsp_valid}, 32'd1);
    chk("R8 second rsp data", rsp_rdata, 32'h0000_0015);
    @(negedge clk);
    chk("R8 rsp drained", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_taskfile();
    t_control_status();
    t_unmapped_byte();
    t_data_port();
    t_wide_unmapped();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule